// File: doc/BRIEF.md
# Event Timestamp Capture Unit

The block runs a 32-bit time counter that steps once per clock. With a 125 MHz clock each step is 8 ns and the counter wraps after about 34.3 seconds. When a selected event occurs, the block latches the counter value and holds it for software. Software reads it through a small word-wide register port.

The event comes from one of two sources. The first is an asynchronous request pin. It passes through a synchronizer, and either its rising or its falling edge is active. The second is an internal, already synchronous trigger pulse. A status word reports a fresh capture, a sticky flag for an event that could not be stored, and a wrapping count of events. Software consumes a capture by writing the status word back with the valid bit at zero, which re-arms the unit. Any write to the status word also clears the event count.

The live counter is read as two words. Reading the low word snapshots the high word, so the following high-word read belongs to the same instant.

Top module: `evt_tstamp_unit`

## Requirements
- R1: The time counter is 0 in reset and increments by one on every clock after reset, wrapping modulo 2^32.
- R2: A read of address 4 returns counter bits [15:0] and snapshots bits [31:16]. A later read of address 5 returns that snapshot, even if the live high half has changed since.
- R3: With source bit clear and active edge set to rising, a rising edge on the request pin captures the counter value two clocks after the pin changes, which is the cycle the synchronized edge is seen.
- R4: Configuration bit 2 (address 0) selects the falling edge when set. A rising edge then captures nothing, and the falling edge captures with the same two-clock delay.
- R5: Status bit 0 (address 1) selects the source. When it is 1, trigger pulses are captured and the pin is ignored. When it is 0, the pin is used and trigger pulses are ignored.
- R6: A capture sets status bit 1 (valid). The captured value reads at address 2 (bits [15:0]) and address 3 (bits [31:16]).
- R7: Writing the status word with bit 1 at zero clears valid, and the next event is captured again.
- R8: An event arriving while valid is set sets sticky status bit 2 (error). With overwrite off (configuration bit 1 clear), it keeps the stored value. The error bit stays set until the status word is written with bit 2 at zero.
- R9: With overwrite on, such an event replaces the stored value with the new counter value and still sets the error bit.
- R10: Status bits [11:8] count detected events, including missed ones, wrapping at 16. Any write to address 1 resets the count to 0.
- R11: With configuration bit 0 (capture enable) clear, events are neither captured nor counted.
- R12: After reset, the configuration and status words read 0. Read data appears on rdata_o one clock after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; one counter step per cycle |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ext_evt_i | input | 1 | Asynchronous event request pin |
| trig_i | input | 1 | Synchronous internal trigger; each high cycle is an event |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 3 | Word address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, registered |

## Verification
The capture path is driven with single pin pulses under both edge polarities, trigger pulses under both source settings, and back-to-back events with overwrite on and off. Comparing each captured value with the bench's own cycle count separates the sync latency from a latch on the wrong cycle. The falling-polarity case shows whether the unused edge leaks through. The pair of events against a still-valid capture tells keep from replace. The live counter is read just before its low half rolls over, which shows whether the high half comes from the snapshot or from the running counter.

// File: rtl/evt_pkg.sv
package evt_pkg;
  localparam int unsigned ADDR_CFG     = 0;
  localparam int unsigned ADDR_STATUS  = 1;
  localparam int unsigned ADDR_CAP_LO  = 2;
  localparam int unsigned ADDR_CAP_HI  = 3;
  localparam int unsigned ADDR_TIME_LO = 4;
  localparam int unsigned ADDR_TIME_HI = 5;

  // configuration word bit positions
  localparam int unsigned CFG_CAP_EN  = 0;
  localparam int unsigned CFG_OVWR    = 1;
  localparam int unsigned CFG_FALLING = 2;

  // status word bit positions
  localparam int unsigned ST_SRC_TRIG = 0;
  localparam int unsigned ST_VALID    = 1;
  localparam int unsigned ST_ERROR    = 2;
  localparam int unsigned ST_SEQ_LSB  = 8;

  typedef struct packed {
    logic falling;
    logic overwrite;
    logic cap_en;
  } evt_cfg_t;
endpackage

// File: rtl/evt_edge_sync.sv
module evt_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  input  logic falling_i,
  output logic edge_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) sync_q[0] <= 1'b0;
          else         sync_q[0] <= async_i;
      end else begin : g_rest
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) sync_q[i] <= 1'b0;
          else         sync_q[i] <= sync_q[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sync_q[STAGES-1];

  assign edge_o = falling_i ? (prev_q & ~sync_q[STAGES-1])
                            : (sync_q[STAGES-1] & ~prev_q);
endmodule

// File: rtl/evt_time_cnt.sv
module evt_time_cnt #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) cnt_o <= '0;
    else         cnt_o <= cnt_o + 1'b1;
endmodule

// File: rtl/evt_capture.sv
module evt_capture #(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned SEQ_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             evt_i,
  input  logic             cap_en_i,
  input  logic             overwrite_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             st_wr_i,
  input  logic             keep_valid_i,
  input  logic             keep_error_i,
  output logic [CNT_W-1:0] ts_o,
  output logic             valid_o,
  output logic             error_o,
  output logic [SEQ_W-1:0] seq_o
);
  logic fire;
  assign fire = evt_i & cap_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ts_o    <= '0;
      valid_o <= 1'b0;
      error_o <= 1'b0;
      seq_o   <= '0;
    end else if (st_wr_i) begin
      // software write has priority over a same-cycle event
      valid_o <= valid_o & keep_valid_i;
      error_o <= error_o & keep_error_i;
      seq_o   <= '0;
    end else if (fire) begin
      seq_o <= seq_o + 1'b1;
      if (!valid_o) begin
        ts_o    <= cnt_i;
        valid_o <= 1'b1;
      end else begin
        error_o <= 1'b1;
        if (overwrite_i) ts_o <= cnt_i;
      end
    end
  end
endmodule

// File: rtl/evt_tstamp_unit.sv
module evt_tstamp_unit #(
  parameter int unsigned WORD_W      = 16,
  parameter int unsigned ADDR_W      = 3,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned SEQ_W       = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ext_evt_i,
  input  logic              trig_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] rdata_o
);
  import evt_pkg::*;

  localparam int unsigned CNT_W = 2 * WORD_W;

  evt_cfg_t          cfg_q;
  logic              src_trig_q;
  logic [CNT_W-1:0]  time_cnt;
  logic [CNT_W-1:0]  cap_ts;
  logic              st_valid;
  logic              st_error;
  logic [SEQ_W-1:0]  st_seq;
  logic              ext_edge;
  logic              evt_sel;
  logic              wr_cfg;
  logic              wr_status;
  logic              rd_req;
  logic [WORD_W-1:0] hi_snap_q;
  logic [WORD_W-1:0] status_word;
  logic [WORD_W-1:0] cfg_word;

  assign wr_cfg    = req_i & we_i & (addr_i == ADDR_W'(ADDR_CFG));
  assign wr_status = req_i & we_i & (addr_i == ADDR_W'(ADDR_STATUS));
  assign rd_req    = req_i & ~we_i;

  evt_time_cnt #(.CNT_W(CNT_W)) i_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cnt_o (time_cnt)
  );

  evt_edge_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .async_i  (ext_evt_i),
    .falling_i(cfg_q.falling),
    .edge_o   (ext_edge)
  );

  assign evt_sel = src_trig_q ? trig_i : ext_edge;

  evt_capture #(.CNT_W(CNT_W), .SEQ_W(SEQ_W)) i_cap (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .evt_i       (evt_sel),
    .cap_en_i    (cfg_q.cap_en),
    .overwrite_i (cfg_q.overwrite),
    .cnt_i       (time_cnt),
    .st_wr_i     (wr_status),
    .keep_valid_i(wdata_i[ST_VALID]),
    .keep_error_i(wdata_i[ST_ERROR]),
    .ts_o        (cap_ts),
    .valid_o     (st_valid),
    .error_o     (st_error),
    .seq_o       (st_seq)
  );

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      cfg_q      <= '0;
      src_trig_q <= 1'b0;
    end else begin
      if (wr_cfg) begin
        cfg_q.cap_en    <= wdata_i[CFG_CAP_EN];
        cfg_q.overwrite <= wdata_i[CFG_OVWR];
        cfg_q.falling   <= wdata_i[CFG_FALLING];
      end
      if (wr_status) src_trig_q <= wdata_i[ST_SRC_TRIG];
    end

  always_comb begin
    cfg_word                       = '0;
    cfg_word[CFG_CAP_EN]           = cfg_q.cap_en;
    cfg_word[CFG_OVWR]             = cfg_q.overwrite;
    cfg_word[CFG_FALLING]          = cfg_q.falling;
    status_word                    = '0;
    status_word[ST_SRC_TRIG]       = src_trig_q;
    status_word[ST_VALID]          = st_valid;
    status_word[ST_ERROR]          = st_error;
    status_word[ST_SEQ_LSB +: SEQ_W] = st_seq;
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      rdata_o   <= '0;
      hi_snap_q <= '0;
    end else if (rd_req) begin
      case (addr_i)
        ADDR_W'(ADDR_CFG):     rdata_o <= cfg_word;
        ADDR_W'(ADDR_STATUS):  rdata_o <= status_word;
        ADDR_W'(ADDR_CAP_LO):  rdata_o <= cap_ts[WORD_W-1:0];
        ADDR_W'(ADDR_CAP_HI):  rdata_o <= cap_ts[CNT_W-1:WORD_W];
        ADDR_W'(ADDR_TIME_LO): begin
          rdata_o   <= time_cnt[WORD_W-1:0];
          hi_snap_q <= time_cnt[CNT_W-1:WORD_W];
        end
        ADDR_W'(ADDR_TIME_HI): rdata_o <= hi_snap_q;
        default:               rdata_o <= '0;
      endcase
    end
endmodule

// File: rtl/evt_tstamp_chk.sv
module evt_tstamp_chk #(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned SEQ_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] ts,
  input logic             valid,
  input logic             error,
  input logic [SEQ_W-1:0] seq,
  input logic             evt,
  input logic             cap_en,
  input logic             ovwr,
  input logic             st_wr
);
  assert_cnt_step_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> cnt == $past(cnt) + 1'b1);

  assert_first_capture_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt && cap_en && !valid && !st_wr) |=> (valid && ts == $past(cnt)));

  assert_keep_on_miss_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt && cap_en && valid && !ovwr && !st_wr) |=> (error && $stable(ts)));

  assert_error_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (error && !st_wr) |=> error);

  assert_replace_on_miss_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt && cap_en && valid && ovwr && !st_wr) |=> (error && ts == $past(cnt)));

  assert_seq_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_wr |=> seq == '0);

  assert_disabled_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cap_en && !st_wr) |=> ($stable(seq) && $stable(ts) && $stable(valid)));
endmodule

bind evt_tstamp_unit evt_tstamp_chk #(.CNT_W(CNT_W), .SEQ_W(SEQ_W)) i_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .cnt   (time_cnt),
  .ts    (cap_ts),
  .valid (st_valid),
  .error (st_error),
  .seq   (st_seq),
  .evt   (evt_sel),
  .cap_en(cfg_q.cap_en),
  .ovwr  (cfg_q.overwrite),
  .st_wr (wr_status)
);

// File: tb/test_evt_tstamp_unit.sv
module test_evt_tstamp_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ext_evt = 1'b0;
  logic        trig = 1'b0;
  logic        req = 1'b0;
  logic        we = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [31:0] tb_cnt;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  evt_tstamp_unit i_evt_tstamp_unit (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .ext_evt_i(ext_evt),
    .trig_i   (trig),
    .req_i    (req),
    .we_i     (we),
    .addr_i   (addr),
    .wdata_i  (wdata),
    .rdata_o  (rdata)
  );

  // model of the free-running counter (R1)
  always @(posedge clk) begin
    if (!rst_n) tb_cnt <= 32'd0;
    else        tb_cnt <= tb_cnt + 32'd1;
  end

  task automatic check(input string req_tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req_tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d, output logic [31:0] at);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a; at = tb_cnt;
    @(negedge clk);
    req = 1'b0;
    d = rdata;
  endtask

  task automatic rd_cap(output logic [31:0] v);
    logic [15:0] lo, hi;
    logic [31:0] t;
    rd(3'd2, lo, t);
    rd(3'd3, hi, t);
    v = {hi, lo};
  endtask

  task automatic rd_st(output logic [15:0] s);
    logic [31:0] t;
    rd(3'd1, s, t);
  endtask

  task automatic pulse_ext(output logic [31:0] at);
    @(negedge clk); ext_evt = 1'b1; at = tb_cnt;
    repeat (3) @(negedge clk);
    ext_evt = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  task automatic pulse_trig(output logic [31:0] at);
    @(negedge clk); trig = 1'b1; at = tb_cnt;
    @(negedge clk); trig = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [15:0] d;
    logic [31:0] at;
    rd(3'd0, d, at); check("R12 cfg after reset", {16'd0, d}, 32'd0);
    rd(3'd1, d, at); check("R12 status after reset", {16'd0, d}, 32'd0);
    rd(3'd4, d, at); check("R1 time low", {16'd0, d}, {16'd0, at[15:0]});
    repeat (7) @(negedge clk);
    rd(3'd4, d, at); check("R1 time low later", {16'd0, d}, {16'd0, at[15:0]});
  endtask

  task automatic t_ext_rise;
    logic [15:0] s;
    logic [31:0] v, c;
    wr(3'd0, 16'h0001);
    wr(3'd1, 16'h0000);
    pulse_ext(v);
    rd_st(s);  check("R6 R10 status after pin capture", {16'd0, s}, 32'h0102);
    rd_cap(c); check("R3 pin capture value", c, v + 32'd2);
  endtask

  task automatic t_rearm;
    logic [15:0] s;
    logic [31:0] v, c;
    wr(3'd1, 16'h0000);
    rd_st(s); check("R7 R10 status after clear", {16'd0, s}, 32'h0000);
    pulse_trig(v);
    rd_st(s); check("R5 trigger ignored with pin source", {16'd0, s}, 32'h0000);
    pulse_ext(v);
    rd_st(s);  check("R7 re-armed status", {16'd0, s}, 32'h0102);
    rd_cap(c); check("R7 re-armed capture", c, v + 32'd2);
  endtask

  task automatic t_missed;
    logic [15:0] s;
    logic [31:0] v1, v2, c;
    rd_cap(v1);
    pulse_ext(v2);
    rd_st(s);  check("R8 R10 error after miss", {16'd0, s}, 32'h0206);
    rd_cap(c); check("R8 value kept", c, v1);
    repeat (4) @(negedge clk);
    rd_st(s);  check("R8 error sticky", {16'd0, s}, 32'h0206);
    wr(3'd1, 16'h0002);
    rd_st(s);  check("R8 error cleared by write", {16'd0, s}, 32'h0002);
    wr(3'd1, 16'h0000);
  endtask

  task automatic t_overwrite;
    logic [15:0] s;
    logic [31:0] v1, v2, c;
    wr(3'd0, 16'h0003);
    wr(3'd1, 16'h0001);
    pulse_trig(v1);
    rd_st(s);  check("R5 trigger status", {16'd0, s}, 32'h0103);
    rd_cap(c); check("R5 trigger capture", c, v1);
    pulse_ext(v2);
    rd_st(s);  check("R5 pin ignored with trigger source", {16'd0, s}, 32'h0103);
    pulse_trig(v2);
    rd_st(s);  check("R9 error with overwrite", {16'd0, s}, 32'h0207);
    rd_cap(c); check("R9 value replaced", c, v2);
  endtask

  task automatic t_falling;
    logic [15:0] s;
    logic [31:0] v, c;
    wr(3'd0, 16'h0005);
    wr(3'd1, 16'h0000);
    @(negedge clk); ext_evt = 1'b1;
    repeat (6) @(negedge clk);
    rd_st(s); check("R4 rising edge ignored", {16'd0, s}, 32'h0000);
    @(negedge clk); ext_evt = 1'b0; v = tb_cnt;
    repeat (6) @(negedge clk);
    rd_st(s);  check("R4 falling status", {16'd0, s}, 32'h0102);
    rd_cap(c); check("R4 falling capture", c, v + 32'd2);
  endtask

  task automatic t_disabled;
    logic [15:0] s;
    logic [31:0] v;
    wr(3'd0, 16'h0000);
    wr(3'd1, 16'h0000);
    pulse_ext(v);
    rd_st(s); check("R11 pin while disabled", {16'd0, s}, 32'h0000);
    wr(3'd1, 16'h0001);
    pulse_trig(v);
    rd_st(s); check("R11 trigger while disabled", {16'd0, s}, 32'h0001);
  endtask

  task automatic t_snapshot;
    logic [15:0] lo, hi;
    logic [31:0] at_lo, at_hi;
    while (tb_cnt[15:0] != 16'hFFFE) @(negedge clk);
    rd(3'd4, lo, at_lo);
    check("R2 low word at rollover", {16'd0, lo}, 32'h0000_FFFF);
    repeat (3) @(negedge clk);
    rd(3'd5, hi, at_hi);
    check("R2 high word from snapshot", {16'd0, hi}, {16'd0, at_lo[31:16]});
    check("R2 live high moved on", at_hi[31:16], at_lo[31:16] + 16'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_ext_rise();
    t_rearm();
    t_missed();
    t_overwrite();
    t_falling();
    t_disabled();
    t_snapshot();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule